// File: doc/BRIEF.md
# Two-Pass 2-D DCT Sequencer

The sequencer runs one two-dimensional transform over a 16 x 16 pixel subframe with a single pipelined one-dimensional transform element. The element sits outside the block and is reached only through an issue/result port pair. Work is timed in fixed units of 12 clock cycles, and each unit can issue one 16-point vector to the element. One block always lasts 34 units. The first 16 units issue the pixel rows, fetched one row per unit from an external line store. Two idle units then let the element's pipeline empty. The last 16 units issue the columns of the intermediate result and forward each column result to the output.

Row results are kept in an internal transpose store. They are written in the order they arrive and read back by column. Each 12-bit intermediate value is written once per block. Pixels are 9-bit unsigned values and are zero-extended to 12 bits before issue. A new block is taken only while the sequencer is idle. One cycle after the block ends, a single-cycle done pulse is raised.

Top module: `dct2d_sequencer`

## Requirements
- R1: A high `start_i` sampled on a clock edge while idle begins a block, and `busy_o` is high from the next cycle for exactly 408 cycles. A `start_i` seen while busy has no effect on the block's timing, outputs or done pulse.
- R2: Call the cycle after the accepting edge cycle 0; unit u covers cycles 12u to 12u+11. `pe_start_o` is high only in the first cycle of units 0-15 and 18-33, and it is never high in units 16 and 17.
- R3: In the first cycle of unit k, for k from 0 to 15, `pix_rd_o` is high, `pix_row_o` equals k, and `pe_vec_o` carries the 16 pixels of `pix_row_i` zero-extended to 12 bits (pixel j in bits 12j+11:12j). `pix_rd_o` is low at all other times.
- R4: `coef_valid_o` is never high during units 0 to 17.
- R5: Row results are stored in arrival order as rows 0 to 15, and they are accepted in both the row units and the two drain units. A row result that arrives during the drain is therefore still used.
- R6: In column unit 18+c, `pe_vec_o` element r is element c of stored row r, which is the transpose.
- R7: A `pe_done_i` in a column unit, which must arrive by the eleventh cycle of that unit, puts `pe_res_i` on `coef_vec_o` in the next cycle, with `coef_valid_o` high and `coef_col_o` = c.
- R8: `done_o` is high in exactly one cycle, cycle 408, which is also the first cycle in which `busy_o` is low again.
- R9: An active-low asynchronous `rst_ni` forces idle: `busy_o`, `done_o`, `coef_valid_o`, `pe_start_o` and `pix_rd_o` are low, including when reset hits in the middle of a block. After reset is released, the next block runs normally.
- R10: A `pe_done_i` received while idle is ignored, and no coefficient is output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Block start request |
| busy_o | output | 1 | Block in progress |
| done_o | output | 1 | One-cycle block completion pulse |
| pix_rd_o | output | 1 | Pixel row fetch strobe |
| pix_row_o | output | 4 | Row index to fetch |
| pix_row_i | input | 144 | 16 pixels of 9 bits, pixel j at bits 9j+8:9j |
| pe_start_o | output | 1 | Issue strobe to the 1-D element |
| pe_vec_o | output | 192 | Issued 16 x 12-bit vector |
| pe_done_i | input | 1 | Result strobe from the 1-D element |
| pe_res_i | input | 192 | 16 x 12-bit result vector |
| coef_valid_o | output | 1 | Coefficient column valid |
| coef_col_o | output | 4 | Column index of the output |
| coef_vec_o | output | 192 | 16 x 12-bit coefficient column |

## Verification
The hardest case to reach is a row result that arrives after the last row has been issued and lands in the drain interval. Only a slow element produces it. The bench's stand-in element delays results separately for rows and columns. A block is run with a 20-cycle and then a 30-cycle row delay, so the last one or two row results arrive in unit 16 or 17. The stand-in's mapping is asymmetric, so any lost or misplaced row shows up in the final columns. A held start during a block and a reset in the middle of a block are also exercised.

// File: rtl/dct2d_seq_pkg.sv
package dct2d_seq_pkg;
  typedef enum logic [1:0] {
    PH_IDLE  = 2'd0,
    PH_ROW   = 2'd1,
    PH_DRAIN = 2'd2,
    PH_COL   = 2'd3
  } phase_e;
endpackage

// File: rtl/dct2d_unit_timer.sv
module dct2d_unit_timer
  import dct2d_seq_pkg::*;
#(
  parameter int N_PTS       = 16,
  parameter int UNIT_CYC    = 12,
  parameter int DRAIN_UNITS = 2,
  localparam int TOTAL_UNITS = 2 * N_PTS + DRAIN_UNITS,
  localparam int UW          = $clog2(TOTAL_UNITS + 1),
  localparam int CW          = $clog2(UNIT_CYC),
  localparam int IW          = $clog2(N_PTS)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          start_i,
  output phase_e        phase_o,
  output logic [CW-1:0] cyc_o,
  output logic [IW-1:0] idx_o,
  output logic          done_o
);
  localparam logic [UW-1:0] LAST_UNIT = UW'(TOTAL_UNITS - 1);
  localparam logic [CW-1:0] LAST_CYC  = CW'(UNIT_CYC - 1);
  localparam logic [UW-1:0] COL_BASE  = UW'(N_PTS + DRAIN_UNITS);

  logic          active_q, done_q;
  logic [UW-1:0] unit_q, col_unit;
  logic [CW-1:0] cyc_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      active_q <= 1'b0;
      done_q   <= 1'b0;
      unit_q   <= '0;
      cyc_q    <= '0;
    end else begin
      done_q <= 1'b0;
      if (!active_q) begin
        if (start_i) begin
          active_q <= 1'b1;
          unit_q   <= '0;
          cyc_q    <= '0;
        end
      end else if (cyc_q == LAST_CYC) begin
        cyc_q <= '0;
        if (unit_q == LAST_UNIT) begin
          active_q <= 1'b0;
          unit_q   <= '0;
          done_q   <= 1'b1;
        end else begin
          unit_q <= unit_q + UW'(1);
        end
      end else begin
        cyc_q <= cyc_q + CW'(1);
      end
    end
  end

  always_comb begin
    if (!active_q)                   phase_o = PH_IDLE;
    else if (unit_q < UW'(N_PTS))    phase_o = PH_ROW;
    else if (unit_q < COL_BASE)      phase_o = PH_DRAIN;
    else                             phase_o = PH_COL;
  end

  assign col_unit = unit_q - COL_BASE;
  assign idx_o    = (phase_o == PH_COL) ? col_unit[IW-1:0] : unit_q[IW-1:0];
  assign cyc_o    = cyc_q;
  assign done_o   = done_q;

  p_unit_wrap_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (active_q && cyc_q == LAST_CYC && unit_q != LAST_UNIT)
      |=> (active_q && cyc_q == '0 && unit_q == $past(unit_q) + UW'(1)));

  p_done_at_end_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (active_q && unit_q == LAST_UNIT && cyc_q == LAST_CYC) |=> (done_q && !active_q));

  p_done_pulse_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_q |=> !done_q);

  p_start_ignored_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (active_q && start_i && !(unit_q == LAST_UNIT && cyc_q == LAST_CYC))
      |=> (active_q && !done_q));
endmodule

// File: rtl/dct2d_tpose_buf.sv
module dct2d_tpose_buf #(
  parameter int N_PTS = 16,
  parameter int DW    = 12,
  localparam int IW   = $clog2(N_PTS),
  localparam int VW   = N_PTS * DW
) (
  input  logic          clk_i,
  input  logic          wr_en_i,
  input  logic [IW-1:0] wr_row_i,
  input  logic [VW-1:0] wr_vec_i,
  input  logic [IW-1:0] rd_col_i,
  output logic [VW-1:0] rd_vec_o
);
  logic [DW-1:0] mem_q [N_PTS][N_PTS];

  // Storage needs no reset: every row is rewritten before the column pass reads it
  always_ff @(posedge clk_i) begin
    if (wr_en_i) begin
      for (int c = 0; c < N_PTS; c++) mem_q[wr_row_i][c] <= wr_vec_i[c*DW +: DW];
    end
  end

  for (genvar r = 0; r < N_PTS; r++) begin : g_col_rd
    assign rd_vec_o[r*DW +: DW] = mem_q[r][rd_col_i];
  end
endmodule

// File: rtl/dct2d_coef_stage.sv
module dct2d_coef_stage #(
  parameter int N_PTS = 16,
  parameter int DW    = 12,
  localparam int IW   = $clog2(N_PTS),
  localparam int VW   = N_PTS * DW
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          cap_i,
  input  logic [IW-1:0] col_i,
  input  logic [VW-1:0] vec_i,
  output logic          valid_o,
  output logic [IW-1:0] col_o,
  output logic [VW-1:0] vec_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_o <= 1'b0;
      col_o   <= '0;
      vec_o   <= '0;
    end else begin
      valid_o <= cap_i;
      if (cap_i) begin
        col_o <= col_i;
        vec_o <= vec_i;
      end
    end
  end
endmodule

// File: rtl/dct2d_sequencer.sv
module dct2d_sequencer
  import dct2d_seq_pkg::*;
#(
  parameter int N_PTS       = 16,
  parameter int UNIT_CYC    = 12,
  parameter int DRAIN_UNITS = 2,
  parameter int PIX_W       = 9,
  parameter int DW          = 12,
  localparam int IW         = $clog2(N_PTS),
  localparam int CW         = $clog2(UNIT_CYC),
  localparam int VW         = N_PTS * DW
) (
  input  logic                   clk_i,
  input  logic                   rst_ni,
  input  logic                   start_i,
  output logic                   busy_o,
  output logic                   done_o,
  output logic                   pix_rd_o,
  output logic [IW-1:0]          pix_row_o,
  input  logic [N_PTS*PIX_W-1:0] pix_row_i,
  output logic                   pe_start_o,
  output logic [VW-1:0]          pe_vec_o,
  input  logic                   pe_done_i,
  input  logic [VW-1:0]          pe_res_i,
  output logic                   coef_valid_o,
  output logic [IW-1:0]          coef_col_o,
  output logic [VW-1:0]          coef_vec_o
);
  localparam logic [IW:0] ROW_LIMIT = (IW+1)'(N_PTS);

  phase_e        phase;
  logic [CW-1:0] cyc;
  logic [IW-1:0] idx;
  logic [IW:0]   wr_cnt_q;
  logic          row_wr, row_window, col_cap;
  logic [VW-1:0] ext_row, col_vec;

  dct2d_unit_timer #(
    .N_PTS(N_PTS), .UNIT_CYC(UNIT_CYC), .DRAIN_UNITS(DRAIN_UNITS)
  ) u_timer (
    .clk_i(clk_i), .rst_ni(rst_ni), .start_i(start_i),
    .phase_o(phase), .cyc_o(cyc), .idx_o(idx), .done_o(done_o)
  );

  assign busy_o     = (phase != PH_IDLE);
  assign pix_rd_o   = (phase == PH_ROW) && (cyc == '0);
  assign pix_row_o  = idx;
  assign pe_start_o = ((phase == PH_ROW) || (phase == PH_COL)) && (cyc == '0);

  for (genvar k = 0; k < N_PTS; k++) begin : g_ext
    assign ext_row[k*DW +: DW] = {{(DW-PIX_W){1'b0}}, pix_row_i[k*PIX_W +: PIX_W]};
  end

  assign pe_vec_o = (phase == PH_COL) ? col_vec : ext_row;

  // Late row results are still taken during the drain units
  assign row_window = (phase == PH_ROW) || (phase == PH_DRAIN);
  assign row_wr     = pe_done_i && row_window && (wr_cnt_q < ROW_LIMIT);
  assign col_cap    = pe_done_i && (phase == PH_COL);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                            wr_cnt_q <= '0;
    else if (phase == PH_IDLE && start_i)   wr_cnt_q <= '0;
    else if (row_wr)                        wr_cnt_q <= wr_cnt_q + (IW+1)'(1);
  end

  dct2d_tpose_buf #(.N_PTS(N_PTS), .DW(DW)) u_tpose (
    .clk_i(clk_i), .wr_en_i(row_wr), .wr_row_i(wr_cnt_q[IW-1:0]),
    .wr_vec_i(pe_res_i), .rd_col_i(idx), .rd_vec_o(col_vec)
  );

  dct2d_coef_stage #(.N_PTS(N_PTS), .DW(DW)) u_out (
    .clk_i(clk_i), .rst_ni(rst_ni), .cap_i(col_cap), .col_i(idx), .vec_i(pe_res_i),
    .valid_o(coef_valid_o), .col_o(coef_col_o), .vec_o(coef_vec_o)
  );

  p_row_count_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pe_done_i && row_window) |-> (wr_cnt_q < ROW_LIMIT));

  p_no_early_coef_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    coef_valid_o |-> $past(phase == PH_COL));

  p_coef_follows_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (phase == PH_COL && pe_done_i) |=> (coef_valid_o && coef_vec_o == $past(pe_res_i)));

  p_idle_ignore_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (phase == PH_IDLE && pe_done_i) |=> !coef_valid_o);
endmodule

// File: tb/dct2d_sequencer_test.sv
module dct2d_sequencer_test;
  localparam int CLK_PERIOD = 10;
  localparam int N   = 16;
  localparam int DW  = 12;
  localparam int PW  = 9;
  localparam int UC  = 12;
  localparam int BLK = 34 * UC;
  localparam int VW  = N * DW;

  logic          clk, rst_n, start, busy, done, pix_rd, pe_start, pe_done, coef_valid;
  logic [3:0]    pix_row, coef_col;
  logic [N*PW-1:0] pix_bus;
  logic [VW-1:0] pe_vec, pe_res, coef_vec;

  dct2d_sequencer uut (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start), .busy_o(busy), .done_o(done),
    .pix_rd_o(pix_rd), .pix_row_o(pix_row), .pix_row_i(pix_bus),
    .pe_start_o(pe_start), .pe_vec_o(pe_vec), .pe_done_i(pe_done), .pe_res_i(pe_res),
    .coef_valid_o(coef_valid), .coef_col_o(coef_col), .coef_vec_o(coef_vec)
  );

  int n_chk = 0, n_err = 0;
  bit finished = 0;

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  logic [PW-1:0] pix [N][N];
  always_comb begin
    for (int k = 0; k < N; k++) pix_bus[k*PW +: PW] = pix[pix_row][k];
  end

  // Stand-in 1-D element: asymmetric map, per-pass latency
  function automatic logic [VW-1:0] pe_fn(input logic [VW-1:0] v);
    logic [VW-1:0] r;
    for (int k = 0; k < N; k++) r[k*DW +: DW] = v[(N-1-k)*DW +: DW] + DW'(k + 1);
    return r;
  endfunction

  bit            sh_v [32];
  bit            sh_row [32];
  logic [VW-1:0] sh_d [32];
  int            row_lat = 4, col_lat = 4;
  logic          inj_done;

  always @(posedge clk) begin
    for (int i = 31; i > 0; i--) begin
      sh_v[i]   <= sh_v[i-1];
      sh_row[i] <= sh_row[i-1];
      sh_d[i]   <= sh_d[i-1];
    end
    sh_v[0]   <= (pe_start === 1'b1);
    sh_row[0] <= (pix_rd === 1'b1);
    sh_d[0]   <= pe_fn(pe_vec);
  end

  always_comb begin
    logic rhit, chit;
    rhit = sh_v[row_lat-1] && sh_row[row_lat-1];
    chit = sh_v[col_lat-1] && !sh_row[col_lat-1];
    pe_done = inj_done || rhit || chit;
    pe_res  = rhit ? sh_d[row_lat-1] : (chit ? sh_d[col_lat-1] : {VW{1'b1}});
  end

  task automatic chk(input bit ok, input string tag, input string what,
                     input logic [VW-1:0] act, input logic [VW-1:0] exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s %s: actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  // Scoreboard
  logic [3:0]    exp_col_q [$];
  logic [VW-1:0] exp_vec_q [$];

  always @(negedge clk) begin
    if (rst_n && coef_valid === 1'b1) begin
      if (exp_vec_q.size() == 0) begin
        chk(0, "R4", "unexpected coefficient", VW'(coef_col), 0);
      end else begin
        logic [3:0]    ec;
        logic [VW-1:0] ev;
        ec = exp_col_q.pop_front();
        ev = exp_vec_q.pop_front();
        chk(coef_col === ec, "R7", "coef column index", VW'(coef_col), VW'(ec));
        chk(coef_vec === ev, "R6", "transposed coefficient column", coef_vec, ev);
      end
    end
  end

  function automatic logic [VW-1:0] ext_row(input int r);
    logic [VW-1:0] v;
    for (int k = 0; k < N; k++) v[k*DW +: DW] = {{(DW-PW){1'b0}}, pix[r][k]};
    return v;
  endfunction

  task automatic load_block(input int seed);
    logic [DW-1:0] rr [N][N];
    logic [VW-1:0] y;
    for (int r = 0; r < N; r++)
      for (int c = 0; c < N; c++)
        pix[r][c] = PW'((r * 37 + c * 11 + seed * 53) ^ (c << 4) ^ (r << 5));
    for (int r = 0; r < N; r++)
      for (int k = 0; k < N; k++)
        rr[r][k] = {{(DW-PW){1'b0}}, pix[r][N-1-k]} + DW'(k + 1);
    for (int c = 0; c < N; c++) begin
      for (int k = 0; k < N; k++) y[k*DW +: DW] = rr[N-1-k][c] + DW'(k + 1);
      exp_col_q.push_back(4'(c));
      exp_vec_q.push_back(y);
    end
  endtask

  task automatic run_block(input int rlat, input int clat, input int seed, input bit hold);
    int e_issue = 0, e_pix = 0, e_early = 0, e_busy = 0, e_done = 0;
    load_block(seed);
    row_lat = rlat;
    col_lat = clat;
    @(negedge clk) start = 1'b1;
    @(posedge clk);
    @(negedge clk);
    if (!hold) start = 1'b0;
    for (int n = 0; n <= BLK; n++) begin
      if (n > 0) begin
        @(posedge clk);
        @(negedge clk);
      end
      if (hold && n == 6) start = 1'b0;
      if (n < BLK) begin
        int u, c;
        bit xs, xr;
        u  = n / UC;
        c  = n % UC;
        xs = (c == 0) && (u < 16 || u >= 18);
        xr = (c == 0) && (u < 16);
        if (pe_start !== xs) e_issue++;
        if (pix_rd !== xr) e_pix++;
        if (xr && (pix_row !== 4'(u) || pe_vec !== ext_row(u))) e_pix++;
        if (u < 18 && coef_valid !== 1'b0) e_early++;
        if (busy !== 1'b1) e_busy++;
        if (done !== 1'b0) e_done++;
      end else begin
        chk(done === 1'b1, "R8", "done pulse at cycle 408", VW'(done), 1);
        chk(busy === 1'b0, "R1", "busy drops at cycle 408", VW'(busy), 0);
      end
    end
    @(posedge clk);
    @(negedge clk);
    chk(done === 1'b0, "R8", "done lasts one cycle", VW'(done), 0);
    chk(busy === 1'b0, "R1", "idle after block", VW'(busy), 0);
    chk(e_issue == 0, "R2", "issue slot mismatches", VW'(e_issue), 0);
    chk(e_pix == 0, "R3", "row fetch/vector mismatches", VW'(e_pix), 0);
    chk(e_early == 0, "R4", "coefficient before column pass", VW'(e_early), 0);
    chk(e_busy == 0, hold ? "R1" : "R1", "busy gaps during block", VW'(e_busy), 0);
    chk(e_done == 0, "R8", "early done pulses", VW'(e_done), 0);
    chk(exp_vec_q.size() == 0, rlat > 16 ? "R5" : "R7", "columns not delivered",
        VW'(exp_vec_q.size()), 0);
  endtask

  initial begin
    rst_n = 1'b0;
    start = 1'b0;
    inj_done = 1'b0;
    for (int i = 0; i < N; i++)
      for (int j = 0; j < N; j++) pix[i][j] = '0;
    repeat (3) @(negedge clk);
    // R9: reset state
    chk(busy === 1'b0 && done === 1'b0, "R9", "busy/done in reset", VW'({busy, done}), 0);
    chk(coef_valid === 1'b0 && pe_start === 1'b0 && pix_rd === 1'b0, "R9",
        "strobes in reset", VW'({coef_valid, pe_start, pix_rd}), 0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);

    // R10: stray result while idle
    inj_done = 1'b1;
    repeat (3) begin
      @(posedge clk);
      @(negedge clk);
      chk(coef_valid === 1'b0, "R10", "idle result ignored", VW'(coef_valid), 0);
    end
    inj_done = 1'b0;
    @(posedge clk);
    @(negedge clk);
    chk(coef_valid === 1'b0 && busy === 1'b0, "R10", "still idle",
        VW'({coef_valid, busy}), 0);

    run_block(4, 4, 1, 1'b0);
    run_block(20, 1, 2, 1'b1);   // R5 last row lands in drain; R1 start held
    run_block(30, 10, 3, 1'b0);  // R5 two rows land in drain

    // R9: reset mid-block
    load_block(7);
    row_lat = 4;
    col_lat = 4;
    @(negedge clk) start = 1'b1;
    @(negedge clk) start = 1'b0;
    repeat (100) @(negedge clk);
    rst_n = 1'b0;
    #1;
    chk(busy === 1'b0 && coef_valid === 1'b0 && done === 1'b0 && pe_start === 1'b0,
        "R9", "mid-block reset clears", VW'({busy, coef_valid, done, pe_start}), 0);
    exp_col_q.delete();
    exp_vec_q.delete();
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    repeat (40) @(negedge clk);
    chk(busy === 1'b0, "R9", "idle after reset release", VW'(busy), 0);
    run_block(6, 7, 9, 1'b0);

    if (!finished) begin
      finished = 1;
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
    end
  end

  initial begin
    #(CLK_PERIOD * 200000);
    if (!finished) begin
      finished = 1;
      n_chk++;
      n_err++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
    end
  end
endmodule